// File: doc/BRIEF.md
# Periodic Battery Health Test Sequencer

This block decides when a backup battery is put under test and what the result means. While the main supply is reported good and the supply supervisor has lifted write protection, the block connects the battery to a test load for a fixed window. During that window it samples a digital comparator that reports whether the battery voltage is above its trip point. After the window it either schedules the next test one period later or raises a latched, active-low battery warning.

A failed result stops periodic testing. The warning stays low until the supply goes away and comes back. Every power-up starts a retest at once, even if the warning is already low. A passing retest releases the warning and starts the periodic schedule again. When power is lost, the block removes the load in the same cycle, drops any test in progress without a verdict and clears its period timer. The analog load and the comparator are outside the block. Lengths are given in clock cycles.

Top module: `batt_chk_seq`

## Requirements
- R1: After reset, load_en is 0 and warn_n is 1, and no test runs until power is reported good.
- R2: Power is good when supply_ok and wp_release are both 1. On the first clock edge at which power is good after it was not, a test starts, so load_en is 1 from that edge on. This happens whatever the state of warn_n.
- R3: A test holds load_en at 1 for exactly WIN_CYC consecutive clock cycles. cmp_ok is sampled on each of the WIN_CYC edges that follow the start of the test.
- R4: After a test passes, load_en stays 0 for exactly PERIOD_CYC cycles, and then the next test starts.
- R5: cmp_ok = 0 means the battery is below its trip point, and cmp_ok = 1 means it is healthy. If any sample in the window reads 0 (the first and the last samples count too), warn_n goes to 0 on the edge that ends the window, the same edge on which load_en falls.
- R6: Once a test has failed, no further periodic test starts while power stays good, and warn_n stays 0.
- R7: A test started by a power-up that passes sets warn_n to 1, and periodic testing resumes PERIOD_CYC cycles later. If that test fails, warn_n stays 0.
- R8: When supply_ok goes to 0, load_en drops to 0 in the same cycle. A test that was in progress ends without a verdict, and warn_n keeps its value while power is absent.
- R9: A loss of power resets the period timer. After power returns, the power-up test runs, and the next test follows it after a full PERIOD_CYC cycles.
- R10: While wp_release is 0, no test runs, even if supply_ok is 1.
- R11: cmp_ok has no effect outside a test window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok | input | 1 | Main supply within tolerance |
| wp_release | input | 1 | Write protection released by the supply supervisor |
| cmp_ok | input | 1 | Battery comparator: 1 = above trip point, 0 = below |
| load_en | output | 1 | Connects the battery to the test load |
| warn_n | output | 1 | Latched battery warning, active low |

## Verification
The sequencer is driven through four kinds of window: a clean window, a window that fails only on its first sample, one that fails only on its last sample, and one in which the comparator reads low only while the block is waiting between tests. Together these separate a verdict taken over the whole window from one taken on a single sample, and from a comparator that is watched all the time. Power-up retests run both with and without a pending warning and with both outcomes. This separates a warning that is sticky across periodic tests from one that never clears. Power is also removed in the middle of a window and in the middle of a wait. These cases show whether the load drops in the same cycle, whether a partial window is thrown away, and whether the period timer restarts from zero or resumes.

// File: rtl/batt_chk_pkg.sv
package batt_chk_pkg;
  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,
    ST_TEST = 2'd1,
    ST_WAIT = 2'd2,
    ST_HALT = 2'd3
  } bc_state_e;
endpackage

// File: rtl/batt_chk_timer.sv
module batt_chk_timer #(
  parameter int unsigned LEN = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic load,
  input  logic en,
  output logic zero
);
  localparam int W = (LEN < 2) ? 1 : $clog2(LEN);
  localparam logic [W-1:0] RELOAD = W'(LEN - 1);

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)
      cnt_d = '0;
    else if (load)
      cnt_d = RELOAD;
    else if (en && (cnt_q != '0))
      cnt_d = cnt_q - W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/batt_chk_ctrl.sv
module batt_chk_ctrl
  import batt_chk_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_ok,
  input  logic cmp_ok,
  input  logic win_zero,
  input  logic per_zero,
  output logic win_load,
  output logic win_en,
  output logic per_load,
  output logic per_en,
  output logic testing,
  output logic warn
);
  bc_state_e st_q, st_d;
  logic fail_q, fail_d;
  logic retest_q, retest_d;
  logic warn_q, warn_d;

  always_comb begin
    st_d     = st_q;
    fail_d   = fail_q;
    retest_d = retest_q;
    warn_d   = warn_q;
    win_load = 1'b0;
    per_load = 1'b0;
    if (!pwr_ok) begin
      st_d = ST_OFF;
    end else begin
      unique case (st_q)
        ST_OFF: begin
          st_d     = ST_TEST;
          win_load = 1'b1;
          fail_d   = 1'b0;
          retest_d = 1'b1;
        end
        ST_TEST: begin
          if (!cmp_ok) fail_d = 1'b1;
          if (win_zero) begin
            if (fail_q || !cmp_ok) begin
              warn_d = 1'b1;
              st_d   = ST_HALT;
            end else begin
              if (retest_q) warn_d = 1'b0;
              st_d     = ST_WAIT;
              per_load = 1'b1;
            end
          end
        end
        ST_WAIT: begin
          if (per_zero) begin
            st_d     = ST_TEST;
            win_load = 1'b1;
            fail_d   = 1'b0;
            retest_d = 1'b0;
          end
        end
        ST_HALT: st_d = ST_HALT;
        default: st_d = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_OFF;
      fail_q   <= 1'b0;
      retest_q <= 1'b0;
      warn_q   <= 1'b0;
    end else begin
      st_q     <= st_d;
      fail_q   <= fail_d;
      retest_q <= retest_d;
      warn_q   <= warn_d;
    end
  end

  assign win_en  = (st_q == ST_TEST);
  assign per_en  = (st_q == ST_WAIT);
  assign testing = (st_q == ST_TEST);
  assign warn    = warn_q;
endmodule

// File: rtl/batt_chk_seq.sv
module batt_chk_seq #(
  parameter int unsigned PERIOD_CYC = 32'd86_400_000,
  parameter int unsigned WIN_CYC    = 32'd1_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok,
  input  logic wp_release,
  input  logic cmp_ok,
  output logic load_en,
  output logic warn_n
);
  logic pwr_ok;
  logic win_load, win_en, win_zero;
  logic per_load, per_en, per_zero;
  logic testing, warn;

  assign pwr_ok = supply_ok & wp_release;

  batt_chk_timer #(.LEN(WIN_CYC)) u_win (
    .clk(clk), .rst_n(rst_n), .clr(!pwr_ok),
    .load(win_load), .en(win_en), .zero(win_zero)
  );

  batt_chk_timer #(.LEN(PERIOD_CYC)) u_per (
    .clk(clk), .rst_n(rst_n), .clr(!pwr_ok),
    .load(per_load), .en(per_en), .zero(per_zero)
  );

  batt_chk_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok), .cmp_ok(cmp_ok),
    .win_zero(win_zero), .per_zero(per_zero),
    .win_load(win_load), .win_en(win_en),
    .per_load(per_load), .per_en(per_en),
    .testing(testing), .warn(warn)
  );

  assign load_en = testing & pwr_ok;
  assign warn_n  = ~warn;
endmodule

// File: rtl/batt_chk_sva.sv
module batt_chk_sva #(
  parameter int unsigned WIN_CYC = 1000
) (
  input logic clk,
  input logic rst_n,
  input logic supply_ok,
  input logic wp_release,
  input logic load_en,
  input logic warn_n
);
  logic [31:0] hi_cnt_q, hi_cnt_d;

  always_comb hi_cnt_d = load_en ? hi_cnt_q + 32'd1 : 32'd0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hi_cnt_q <= 32'd0;
    else        hi_cnt_q <= hi_cnt_d;
  end

  // R3: the load is never held longer than one window
  a_r3_window_len: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |-> (hi_cnt_q < WIN_CYC));

  // R5: the warning moves only on the edge that closes a window
  a_r5_warn_moves_at_window_end: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(warn_n) |-> $past(load_en));

  // R6: while warned, a new test can only come from a power-up
  a_r6_no_test_while_warned: assert property (@(posedge clk) disable iff (!rst_n)
    (load_en && !$past(load_en) && !warn_n) |-> !$past(supply_ok && wp_release, 2));

  // R8: losing the supply leaves the warning untouched
  a_r8_warn_kept_on_power_loss: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> $stable(warn_n));

  // R10: without release, no load in the following cycle
  a_r10_no_test_without_release: assert property (@(posedge clk) disable iff (!rst_n)
    !wp_release |=> !load_en);
endmodule

bind batt_chk_seq batt_chk_sva #(.WIN_CYC(WIN_CYC)) u_sva (
  .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .wp_release(wp_release),
  .load_en(load_en), .warn_n(warn_n)
);

// File: tb/sim_batt_chk_seq.sv
module sim_batt_chk_seq;
  localparam int PER = 40;
  localparam int WIN = 5;

  logic clk = 1'b0;
  logic rst_n, supply_ok, wp_release, cmp_ok;
  logic load_en, warn_n;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  batt_chk_seq #(.PERIOD_CYC(PER), .WIN_CYC(WIN)) u0 (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .wp_release(wp_release),
    .cmp_ok(cmp_ok), .load_en(load_en), .warn_n(warn_n)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic count_low(output int n);
    n = 0;
    while (load_en == 1'b0 && n < 10*PER) begin
      tick();
      n++;
    end
  endtask

  // drives cmp_ok per window cycle; fail_at = -1 means clean window
  task automatic run_window(input int fail_at, output int n);
    n = 0;
    while (load_en == 1'b1 && n < 4*WIN) begin
      cmp_ok = (n != fail_at);
      tick();
      n++;
    end
    cmp_ok = 1'b1;
  endtask

  task automatic power_cycle();
    supply_ok = 1'b0;
    repeat (3) tick();
    supply_ok = 1'b1;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; supply_ok = 1'b0; wp_release = 1'b0; cmp_ok = 1'b1;
    repeat (3) tick();
    check("R1 load_en in reset", load_en, 0);
    check("R1 warn_n in reset", warn_n, 1);
    rst_n = 1'b1;
    repeat (5) tick();
    check("R1 idle without power", load_en, 0);
  endtask

  task automatic t_no_release();
    int seen = 0;
    supply_ok = 1'b1; wp_release = 1'b0; cmp_ok = 1'b0;
    for (int i = 0; i < 2*PER; i++) begin
      tick();
      if (load_en) seen++;
    end
    check("R10 no load without release", seen, 0);
    check("R10 warn_n untouched", warn_n, 1);
    cmp_ok = 1'b1;
  endtask

  task automatic t_powerup_pass();
    int n;
    wp_release = 1'b1;
    count_low(n);
    check("R2 power-up test starts next edge", n, 1);
    run_window(-1, n);
    check("R3 window length", n, WIN);
    check("R3 clean window keeps warn_n", warn_n, 1);
    cmp_ok = 1'b0; // R11: low between windows
    count_low(n);
    check("R4 gap between tests", n, PER);
    run_window(-1, n);
    check("R11 comparator ignored outside window", warn_n, 1);
  endtask

  task automatic t_fail_last_and_sticky();
    int n;
    int seen = 0;
    count_low(n);
    check("R4 second gap", n, PER);
    run_window(WIN-1, n);
    check("R5 window length on fail", n, WIN);
    check("R5 last-sample fail sets warning", warn_n, 0);
    for (int i = 0; i < 3*PER; i++) begin
      tick();
      if (load_en) seen++;
    end
    check("R6 no periodic test after fail", seen, 0);
    check("R6 warning sticky", warn_n, 0);
  endtask

  task automatic t_retest_pass();
    int n;
    supply_ok = 1'b0;
    repeat (4) tick();
    check("R8 warning kept while powered off", warn_n, 0);
    supply_ok = 1'b1;
    count_low(n);
    check("R2 retest while warned", n, 1);
    check("R7 warning held during retest", warn_n, 0);
    run_window(-1, n);
    check("R7 passing retest clears warning", warn_n, 1);
    count_low(n);
    check("R7 periodic testing resumes", n, PER);
  endtask

  task automatic t_first_fail_then_retest_fail();
    int n;
    run_window(0, n);
    check("R5 first-sample fail sets warning", warn_n, 0);
    power_cycle();
    count_low(n);
    check("R2 retest after fail", n, 1);
    run_window(2, n);
    check("R7 failing retest keeps warning", warn_n, 0);
  endtask

  task automatic t_abort_and_period_reset();
    int n;
    power_cycle();
    count_low(n);
    run_window(-1, n);
    check("R7 retest pass before abort test", warn_n, 1);
    count_low(n);
    cmp_ok = 1'b0;
    repeat (2) tick();
    supply_ok = 1'b0;
    #1;
    check("R8 load drops in same cycle", load_en, 0);
    cmp_ok = 1'b1;
    repeat (3) tick();
    check("R8 aborted window gives no verdict", warn_n, 1);
    supply_ok = 1'b1;
    count_low(n);
    run_window(-1, n);
    repeat (PER/2) tick();
    power_cycle();
    count_low(n);
    check("R9 retest right after restore", n, 1);
    run_window(-1, n);
    count_low(n);
    check("R9 full period after restore", n, PER);
    check("R9 warning stays clear", warn_n, 1);
  endtask

  initial begin
    t_reset();
    t_no_release();
    t_powerup_pass();
    t_fail_last_and_sticky();
    t_retest_pass();
    t_first_fail_then_retest_fail();
    t_abort_and_period_reset();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule